// File: doc/BRIEF.md
# Retry-Handshake Port Adapter for a Shared Blocking Target

This block places several requester ports in front of one shared target. The target takes one request at a time and passes it on to a memory-side port. Flow control does not use valid/ready. A request that cannot be taken is refused in the same cycle. The port then records that it owes the requester a retry notice, and it sends that notice once the target is free. A response that the requester refuses is parked in a one-entry slot on that port. The port offers it again after the requester raises its response-retry line. The memory-side port follows the same scheme: a request that memory refuses is parked and presented again after memory signals retry.

Each port has a fixed index. The index of the accepting port is recorded when a request is taken, and the response returns only to that port. When several ports owe notices, the notices go out one per cycle, lowest index first.

Top module: `retry_port_hub`

## Requirements
- R1: After reset no port accepts, no retry notice is sent, no response is offered and no memory request is valid.
- R2: `req_accept[i]` is driven in the same cycle as `req_valid[i]`. It is 1 only when all of these hold: the target is idle, port i holds no response and owes no notice. When several ports qualify in one cycle, only the lowest index is accepted. A port holding a response does not stop other ports from being accepted.
- R3: A refused request (`req_valid[i]=1`, `req_accept[i]=0`) sets the owes-notice flag of port i. A request refused in the same cycle that its notice is sent leaves the flag set.
- R4: `retry_req[i]` is 1 only when all of these hold: port i owes a notice, holds no response, the target is idle and no request is accepted in that cycle. Sending the notice clears the flag. The target becomes idle in the cycle after it delivers a response.
- R5: The response is offered (`rsp_valid[i]`, `rsp_data` lane i) in the same cycle as `mem_rsp_valid`. If `rsp_accept[i]` is 0 in that cycle, the response is held and `rsp_valid[i]` drops the next cycle. A second response never reaches a port whose slot is full.
- R6: One cycle after `rsp_retry[i]`, a held response is offered again with the same data. If it is refused again it stays held. Once it is accepted, an owed notice for that port is issued the following cycle.
- R7: An accepted request appears on `mem_req_valid`, `mem_req_addr` and `mem_req_data` in the next cycle. If `mem_req_accept` is 0 then, the valid drops. The same request is offered again one cycle after `mem_req_retry`.
- R8: A response is offered only on the lane whose index was recorded when its request was accepted.
- R9: Owed notices are issued at most one per cycle, in ascending port index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request attempt per port |
| req_addr | input | NPORT*AW | Request address, lane i at [i*AW +: AW] |
| req_data | input | NPORT*DW | Request payload, lane i at [i*DW +: DW] |
| req_accept | output | NPORT | Same-cycle acceptance; 0 with req_valid means refused |
| retry_req | output | NPORT | Retry notice pulse to the requester |
| rsp_valid | output | NPORT | Response offered per port |
| rsp_data | output | NPORT*DW | Response data, lane i at [i*DW +: DW] |
| rsp_accept | input | NPORT | Requester takes the offered response this cycle |
| rsp_retry | input | NPORT | Requester can now take a held response |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_addr | output | AW | Memory request address |
| mem_req_data | output | DW | Memory request payload |
| mem_req_accept | input | 1 | Memory takes the request this cycle |
| mem_req_retry | input | 1 | Memory can now take a refused request |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | DW | Memory response data |

## Verification
A fresh response can reach one port in the same cycle that another port resends its held response, so two response lanes are active at once with different data. The bench sets this up as follows. It parks port 0's response, starts a transaction on port 2, and pulses port 0's response retry one cycle before memory answers. It then requires both lanes valid together, each carrying its own data. The same bench also makes a notice and a fresh request from the same port coincide, and checks that the flag stays set and the notice repeats.

// File: rtl/retry_hub_pkg.sv
package retry_hub_pkg;
  typedef enum logic [1:0] {
    TG_IDLE = 2'd0,
    TG_SEND = 2'd1,
    TG_HELD = 2'd2,
    TG_WAIT = 2'd3
  } tgt_state_e;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rp_pick.sv
module rp_pick #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] want,
  output logic [N-1:0] pick
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (want[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rp_port.sv
module rp_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          tgt_idle,
  input  logic          grant,
  input  logic          notice_go,
  input  logic          deliver,
  input  logic [DW-1:0] deliver_data,
  input  logic          rsp_accept,
  input  logic          rsp_retry,
  output logic          cand,
  output logic          notice_want,
  output logic          owes,
  output logic          slot_full,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic          held;
  logic          resend;
  logic [DW-1:0] held_data;
  logic          refused;

  assign refused     = req_valid && !grant;
  assign cand        = req_valid && !held && !owes && tgt_idle;
  assign notice_want = owes && !held;
  assign slot_full   = held;
  assign rsp_valid   = deliver || resend;
  assign rsp_data    = deliver ? deliver_data : held_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owes <= 1'b0;
    end else if (refused) begin
      owes <= 1'b1;
    end else if (notice_go) begin
      owes <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      resend    <= 1'b0;
      held_data <= '0;
    end else begin
      if (deliver && !rsp_accept) begin
        held      <= 1'b1;
        held_data <= deliver_data;
      end else if (resend && rsp_accept) begin
        held <= 1'b0;
      end
      resend <= rsp_retry && held && !(resend && rsp_accept);
    end
  end
endmodule

// File: rtl/rp_target.sv
module rp_target
  import retry_hub_pkg::*;
#(
  parameter int unsigned N  = 3,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned IW = idx_w(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  input  logic [AW-1:0] take_addr,
  input  logic [DW-1:0] take_data,
  input  logic          mem_req_accept,
  input  logic          mem_req_retry,
  input  logic          mem_rsp_valid,
  output logic          idle,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  output logic [N-1:0]  deliver_vec
);
  tgt_state_e    st;
  logic [IW-1:0] owner;
  logic          finish;

  assign idle          = (st == TG_IDLE);
  assign mem_req_valid = (st == TG_SEND);
  assign finish        = (st == TG_WAIT) && mem_rsp_valid;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      deliver_vec[i] = finish && (owner == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= TG_IDLE;
      owner        <= '0;
      mem_req_addr <= '0;
      mem_req_data <= '0;
    end else begin
      unique case (st)
        TG_IDLE: if (take) begin
          st           <= TG_SEND;
          owner        <= take_idx;
          mem_req_addr <= take_addr;
          mem_req_data <= take_data;
        end
        TG_SEND: st <= mem_req_accept ? TG_WAIT : TG_HELD;
        TG_HELD: if (mem_req_retry) st <= TG_SEND;
        TG_WAIT: if (mem_rsp_valid) st <= TG_IDLE;
        default: st <= TG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/retry_port_hub.sv
module retry_port_hub
  import retry_hub_pkg::*;
#(
  parameter int unsigned NPORT = 3,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = idx_w(NPORT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [NPORT*DW-1:0] req_data,
  output logic [NPORT-1:0]    req_accept,
  output logic [NPORT-1:0]    retry_req,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [NPORT*DW-1:0] rsp_data,
  input  logic [NPORT-1:0]    rsp_accept,
  input  logic [NPORT-1:0]    rsp_retry,
  output logic                mem_req_valid,
  output logic [AW-1:0]       mem_req_addr,
  output logic [DW-1:0]       mem_req_data,
  input  logic                mem_req_accept,
  input  logic                mem_req_retry,
  input  logic                mem_rsp_valid,
  input  logic [DW-1:0]       mem_rsp_data
);
  logic [NPORT-1:0] cand_vec;
  logic [NPORT-1:0] notice_want_vec;
  logic [NPORT-1:0] notice_ok;
  logic [NPORT-1:0] owes_vec;
  logic [NPORT-1:0] slot_full_vec;
  logic [NPORT-1:0] deliver_vec;
  logic             tgt_idle;
  logic             acc_any;
  logic [IW-1:0]    acc_idx;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    acc_data;

  rp_pick #(.N(NPORT)) u_grant (.want(cand_vec), .pick(req_accept));

  assign acc_any   = |req_accept;
  assign notice_ok = notice_want_vec & {NPORT{tgt_idle && !acc_any}};

  rp_pick #(.N(NPORT)) u_notice (.want(notice_ok), .pick(retry_req));

  always_comb begin
    acc_idx  = '0;
    acc_addr = '0;
    acc_data = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (req_accept[i]) begin
        acc_idx  = IW'(i);
        acc_addr = req_addr[i*AW +: AW];
        acc_data = req_data[i*DW +: DW];
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    rp_port #(.DW(DW)) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid[g]),
      .tgt_idle     (tgt_idle),
      .grant        (req_accept[g]),
      .notice_go    (retry_req[g]),
      .deliver      (deliver_vec[g]),
      .deliver_data (mem_rsp_data),
      .rsp_accept   (rsp_accept[g]),
      .rsp_retry    (rsp_retry[g]),
      .cand         (cand_vec[g]),
      .notice_want  (notice_want_vec[g]),
      .owes         (owes_vec[g]),
      .slot_full    (slot_full_vec[g]),
      .rsp_valid    (rsp_valid[g]),
      .rsp_data     (rsp_data[g*DW +: DW])
    );
  end

  rp_target #(.N(NPORT), .AW(AW), .DW(DW)) u_target (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (acc_any),
    .take_idx       (acc_idx),
    .take_addr      (acc_addr),
    .take_data      (acc_data),
    .mem_req_accept (mem_req_accept),
    .mem_req_retry  (mem_req_retry),
    .mem_rsp_valid  (mem_rsp_valid),
    .idle           (tgt_idle),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_req_data   (mem_req_data),
    .deliver_vec    (deliver_vec)
  );
endmodule

// File: rtl/retry_port_hub_chk.sv
module retry_port_hub_chk #(
  parameter int unsigned NPORT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] req_valid,
  input logic [NPORT-1:0] req_accept,
  input logic [NPORT-1:0] retry_req,
  input logic [NPORT-1:0] rsp_valid,
  input logic [NPORT-1:0] rsp_accept,
  input logic [NPORT-1:0] owes_vec,
  input logic [NPORT-1:0] slot_full_vec,
  input logic [NPORT-1:0] deliver_vec,
  input logic             tgt_idle,
  input logic             mem_req_valid,
  input logic             mem_req_accept
);
  a_r2_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_accept));
  a_r2_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept != '0) |-> tgt_idle);
  a_r3_refusal_owes: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid & ~req_accept) != '0) |=> (($past(req_valid & ~req_accept) & ~owes_vec) == '0));
  a_r4_notice_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req != '0) |-> (tgt_idle && (req_accept == '0)));
  a_r5_no_double_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ((deliver_vec & slot_full_vec) == '0));
  a_r6_refused_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_valid & ~rsp_accept) != '0) |=> ((rsp_valid & $past(rsp_valid & ~rsp_accept)) == '0));
  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_accept) |=> !mem_req_valid);
  a_r8_single_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(deliver_vec));
  a_r9_one_notice: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retry_req));
endmodule

bind retry_port_hub retry_port_hub_chk #(.NPORT(NPORT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_accept     (req_accept),
  .retry_req      (retry_req),
  .rsp_valid      (rsp_valid),
  .rsp_accept     (rsp_accept),
  .owes_vec       (owes_vec),
  .slot_full_vec  (slot_full_vec),
  .deliver_vec    (deliver_vec),
  .tgt_idle       (tgt_idle),
  .mem_req_valid  (mem_req_valid),
  .mem_req_accept (mem_req_accept)
);

// File: tb/sim_retry_port_hub.sv
module sim_retry_port_hub;
  localparam int NP = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]   req_valid = '0;
  logic [NP*8-1:0] req_addr = '0;
  logic [NP*8-1:0] req_data = '0;
  logic [NP-1:0]   req_accept, retry_req, rsp_valid;
  logic [NP*8-1:0] rsp_data;
  logic [NP-1:0]   rsp_accept = '0;
  logic [NP-1:0]   rsp_retry = '0;
  logic            mem_req_valid;
  logic [7:0]      mem_req_addr, mem_req_data;
  logic            mem_req_accept = 1'b0;
  logic            mem_req_retry = 1'b0;
  logic            mem_rsp_valid = 1'b0;
  logic [7:0]      mem_rsp_data = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  retry_port_hub #(.NPORT(NP), .AW(8), .DW(8)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [NP-1:0] lowbit(input logic [NP-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] w;
    int wi;
    logic [7:0] d;
    repeat (3) tick();
    #1;
    chk(req_accept == 0 && retry_req == 0 && rsp_valid == 0 && mem_req_valid == 0,
        "R1 reset outputs", {req_accept, retry_req, rsp_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    tick();

    // Sweep all simultaneous request patterns
    for (int pat = 1; pat < 8; pat++) begin
      w = lowbit(NP'(pat));
      wi = 0;
      for (int i = 0; i < NP; i++) if (w[i]) wi = i;
      for (int i = 0; i < NP; i++) begin
        req_addr[i*8 +: 8] = 8'(16 * (i + 1) + pat);
        req_data[i*8 +: 8] = 8'(pat * 3 + i);
      end
      req_valid = NP'(pat);
      #1;
      chk(req_accept == w, "R2 lowest index accepted", req_accept, w);
      chk(retry_req == 0, "R4 no notice on accept cycle", retry_req, 0);
      tick();
      req_valid = w;
      mem_req_accept = (pat % 2 == 1) ? 1'b0 : 1'b1;
      #1;
      chk(req_accept == 0, "R3 busy refusal", req_accept, 0);
      chk(mem_req_valid == 1'b1, "R7 mem valid next cycle", mem_req_valid, 1);
      chk(mem_req_addr == 8'(16 * (wi + 1) + pat), "R7 mem addr", mem_req_addr, 16 * (wi + 1) + pat);
      chk(mem_req_data == 8'(pat * 3 + wi), "R7 mem data", mem_req_data, pat * 3 + wi);
      tick();
      req_valid = '0;
      mem_req_accept = 1'b0;
      if (pat % 2 == 1) begin
        #1;
        chk(mem_req_valid == 1'b0, "R7 held request drops", mem_req_valid, 0);
        chk(retry_req == 0, "R4 no notice while busy", retry_req, 0);
        mem_req_retry = 1'b1;
        tick();
        mem_req_retry = 1'b0;
        mem_req_accept = 1'b1;
        #1;
        chk(mem_req_valid == 1'b1 && mem_req_addr == 8'(16 * (wi + 1) + pat),
            "R7 resend after retry", mem_req_addr, 16 * (wi + 1) + pat);
        tick();
        mem_req_accept = 1'b0;
      end
      d = 8'(8'hC0 + pat);
      mem_rsp_valid = 1'b1;
      mem_rsp_data = d;
      rsp_accept = '1;
      #1;
      chk(rsp_valid == w, "R8 routed to owner", rsp_valid, w);
      chk(rsp_data[wi*8 +: 8] == d, "R5 response data", rsp_data[wi*8 +: 8], d);
      chk(retry_req == 0, "R4 no notice before free", retry_req, 0);
      tick();
      mem_rsp_valid = 1'b0;
      rsp_accept = '0;
      for (int i = 0; i < NP; i++) begin
        if (pat[i]) begin
          #1;
          chk(retry_req == NP'(1 << i), "R9 ascending notice", retry_req, 1 << i);
          tick();
        end
      end
      #1;
      chk(retry_req == 0, "R4 flags cleared", retry_req, 0);
      tick();
    end

    // Held response on port 1
    req_addr[15:8] = 8'h5A;
    req_valid = 3'b010;
    #1; chk(req_accept == 3'b010, "R2 single accept", req_accept, 2);
    tick(); req_valid = '0; mem_req_accept = 1'b1;
    tick(); mem_req_accept = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 8'hA5; rsp_accept = '0;
    #1; chk(rsp_valid == 3'b010, "R5 offered", rsp_valid, 2);
    tick(); mem_rsp_valid = 1'b0;
    req_valid = 3'b010;
    #1;
    chk(req_accept == 0, "R3 refused while holding", req_accept, 0);
    chk(rsp_valid == 0, "R5 held drops valid", rsp_valid, 0);
    tick(); req_valid = '0;
    #1; chk(retry_req == 0, "R4 no notice while holding", retry_req, 0);
    rsp_retry = 3'b010;
    tick(); rsp_retry = '0;
    #1;
    chk(rsp_valid == 3'b010 && rsp_data[15:8] == 8'hA5, "R6 resend", rsp_data[15:8], 8'hA5);
    chk(retry_req == 0, "R4 no notice during resend", retry_req, 0);
    tick();
    #1; chk(rsp_valid == 0, "R6 refused again stays held", rsp_valid, 0);
    rsp_retry = 3'b010;
    tick(); rsp_retry = '0; rsp_accept = 3'b010;
    #1; chk(rsp_valid == 3'b010 && rsp_data[15:8] == 8'hA5, "R6 second resend", rsp_data[15:8], 8'hA5);
    tick(); rsp_accept = '0;
    req_valid = 3'b010;
    #1;
    chk(retry_req == 3'b010, "R6 notice after release", retry_req, 2);
    chk(req_accept == 0, "R3 owed flag blocks", req_accept, 0);
    tick(); req_valid = '0;
    #1; chk(retry_req == 3'b010, "R3 flag kept by refusal", retry_req, 2);
    tick();
    req_valid = 3'b010;
    #1;
    chk(retry_req == 0, "R4 notice cleared flag", retry_req, 0);
    chk(req_accept == 3'b010, "R2 accept after notice", req_accept, 2);
    tick(); req_valid = '0; mem_req_accept = 1'b1;
    #1; chk(mem_req_addr == 8'h5A, "R7 addr", mem_req_addr, 8'h5A);
    tick(); mem_req_accept = 1'b0;
    mem_rsp_valid = 1'b1; rsp_accept = 3'b010;
    tick(); mem_rsp_valid = 1'b0; rsp_accept = '0;

    // Fresh delivery on port 2 coinciding with resend on port 0
    req_valid = 3'b001;
    #1; chk(req_accept == 3'b001, "R2 port0 accept", req_accept, 1);
    tick(); req_valid = '0; mem_req_accept = 1'b1;
    tick(); mem_req_accept = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 8'h11;
    tick(); mem_rsp_valid = 1'b0;
    req_addr[23:16] = 8'h77;
    req_valid = 3'b100;
    #1; chk(req_accept == 3'b100, "R2 holder does not block others", req_accept, 4);
    tick(); req_valid = '0; mem_req_accept = 1'b1;
    #1; chk(mem_req_addr == 8'h77, "R7 port2 addr", mem_req_addr, 8'h77);
    tick(); mem_req_accept = 1'b0; rsp_retry = 3'b001;
    tick(); rsp_retry = '0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 8'h22; rsp_accept = 3'b101;
    #1;
    chk(rsp_valid == 3'b101, "R8 concurrent lanes", rsp_valid, 5);
    chk(rsp_data[7:0] == 8'h11, "R6 lane0 held data", rsp_data[7:0], 8'h11);
    chk(rsp_data[23:16] == 8'h22, "R5 lane2 fresh data", rsp_data[23:16], 8'h22);
    tick(); mem_rsp_valid = 1'b0; rsp_accept = '0;
    #1; chk(rsp_valid == 0 && retry_req == 0, "R4 quiet after", {rsp_valid, retry_req}, 0);
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule